// File: doc/BRIEF.md
# Four-Voice Polynomial Sound Generator

This block makes four sound voices from programmable 8-bit frequency dividers. Each voice is either a square wave or a noise pattern. The noise comes from three shared pseudo-random shift registers of 4, 5 and 17 bits, and the 17-bit one can be shortened to 9 bits. A global control byte does four things: it picks the base clock rate, lets voice 0 and voice 2 run at the full system clock, chains voice pairs into 16-bit dividers, and gates voice 0 by voice 2 and voice 1 by voice 3 as simple high-pass filters. Each voice has its own 4-bit volume. The block adds the volumes of all voices whose output is high and presents the sum as a 6-bit digital level, ready for an external DAC.

Software programs the block through a one-cycle write strobe with a 4-bit address:

| Address | Register |
|---|---|
| 2·N | Divider value of voice N (N = 0 to 3) |
| 2·N+1 | Control byte of voice N |
| 8 | Global control byte |
| 9 to 15 | Ignored |

A read-only port returns eight bits of the long shift register as a random number.

Top module: `poly_tone_gen`

## Requirements
- R1: While reset is held, `mix_out` is 0 and `rnd_data` is 0xFF. Reset clears every register, so after release `mix_out` stays 0 until something is written.
- R2: Control bit 4 set forces the voice on. It then adds its volume (control bits 3:0) to the mix whatever its divider is doing. `mix_out` is the registered sum of the volumes of all voices that are on, from 0 to 60. It follows a register write by two cycles.
- R3: A voice with control bits 7 and 5 set is a pure tone. Its output toggles once every (divider value + 1) ticks of its clock. Global bit 6 makes voice 0 tick on every system clock. Global bit 5 does the same for voice 2.
- R4: All other voices tick once every 28 system clocks. Setting global bit 0 changes this base rate to once every 114 clocks.
- R5: Global bit 4 chains voices 0 and 1, and global bit 3 chains voices 2 and 3. In a chain the higher voice toggles every ({high divider, low divider} + 1) ticks of the lower voice's clock. The lower voice is silent unless bit 4 of its control byte forces it on.
- R6: Writing a divider value does not restart the count in progress. The new value is used from the next reload onward.
- R7: At each underflow, a voice with control bit 7 clear toggles only when the 5-bit register's output is 1. With control bit 5 clear, the voice output takes a noise bit instead of toggling. Control bit 6 set takes the 4-bit register's output (period 15, eight ones per period). Control bit 6 clear takes the long register's output (the 9-bit one has period 511 and 256 ones per period).
- R8: Global bit 2 makes voice 0 sound as its output XOR a latch, and global bit 1 does the same for voice 1. The latch for voice 0 samples voice 0's output at each underflow of voice 2. The latch for voice 1 samples voice 1's output at each underflow of voice 3.
- R9: `rnd_data` is the top eight bits of the long register and shifts by one bit each clock. With global bit 7 set, the long register is 9 bits wide with period 511. With global bit 7 clear, it is 17 bits wide with period 131071.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| rnd_data | output | 8 | Random byte from the long shift register |
| mix_out | output | 6 | Summed level of the voices that are on |

## Verification
A wrong divider count or a bad reload shows as the wrong gap between changes of `mix_out`. In fast-clock mode that is visible within a few cycles. With the base clocks it takes a few hundred cycles. A shift register with wrong taps changes the count of ones and the repeat distance of a noise voice or of `rnd_data`. The 4- and 5-bit registers give themselves away within a few dozen cycles and the 9-bit one within about a thousand. The 17-bit register needs a full period of 131071 cycles before its repeat can be confirmed. A high-pass latch that samples at the wrong time turns a one-cycle pulse into a square wave, or a steady level into a toggling one, within one period of the tone.

// File: rtl/poly_tone_gen.sv
module poly_tone_gen #(
  parameter int BASE_DIV = 28,
  parameter int SLOW_DIV = 114
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [3:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rnd_data,
  output logic [5:0] mix_out
);
  localparam int MAXDIV = (SLOW_DIV > BASE_DIV) ? SLOW_DIV : BASE_DIV;
  localparam int PW = $clog2(MAXDIV);

  logic [7:0] freq [4];
  logic [7:0] ctrl [4];
  logic [7:0] gctl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        freq[i] <= '0;
        ctrl[i] <= '0;
      end
      gctl <= '0;
    end else if (wr_en) begin
      if (!wr_addr[3]) begin
        if (wr_addr[0]) ctrl[wr_addr[2:1]] <= wr_data;
        else            freq[wr_addr[2:1]] <= wr_data;
      end else if (wr_addr[2:0] == 3'd0) begin
        gctl <= wr_data;
      end
    end
  end

  logic [PW-1:0] pre;
  logic          base_tick;
  assign base_tick = (pre == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)         pre <= PW'(BASE_DIV - 1);
    else if (base_tick) pre <= gctl[0] ? PW'(SLOW_DIV - 1) : PW'(BASE_DIV - 1);
    else                pre <= pre - 1'b1;
  end

  logic [3:0]  p4_q;
  logic [4:0]  p5_q;
  logic [8:0]  p9_q;
  logic [16:0] p17_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p4_q  <= '1;
      p5_q  <= '1;
      p9_q  <= '1;
      p17_q <= '1;
    end else begin
      p4_q  <= {p4_q[2:0], p4_q[3] ^ p4_q[2]};
      p5_q  <= {p5_q[3:0], p5_q[4] ^ p5_q[2]};
      p9_q  <= {p9_q[7:0], p9_q[8] ^ p9_q[4]};
      p17_q <= {p17_q[15:0], p17_q[16] ^ p17_q[13]};
    end
  end

  logic poly4, poly5, poly_long;
  assign poly4     = p4_q[3];
  assign poly5     = p5_q[4];
  assign poly_long = gctl[7] ? p9_q[8] : p17_q[16];
  assign rnd_data  = gctl[7] ? p9_q[8:1] : p17_q[16:9];

  logic [1:0] pair, fast;
  logic [3:0] uf;
  assign pair = {gctl[3], gctl[4]};
  assign fast = {gctl[5], gctl[6]};

  for (genvar p = 0; p < 2; p++) begin : g_pair
    localparam int LO = 2 * p;
    localparam int HI = 2 * p + 1;
    logic       t_lo, t_hi;
    logic [7:0] c_lo, c_hi;
    logic       z16;

    assign t_lo = fast[p] | base_tick;
    assign t_hi = pair[p] ? t_lo : base_tick;
    assign z16  = ({c_hi, c_lo} == 16'd0);
    assign uf[LO] = !pair[p] && t_lo && (c_lo == 8'd0);
    assign uf[HI] = pair[p] ? (t_lo && z16) : (t_hi && (c_hi == 8'd0));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        c_lo <= '0;
        c_hi <= '0;
      end else if (pair[p]) begin
        if (t_lo) {c_hi, c_lo} <= z16 ? {freq[HI], freq[LO]} : {c_hi, c_lo} - 16'd1;
      end else begin
        if (t_lo) c_lo <= (c_lo == 8'd0) ? freq[LO] : c_lo - 8'd1;
        if (t_hi) c_hi <= (c_hi == 8'd0) ? freq[HI] : c_hi - 8'd1;
      end
    end
  end

  logic [3:0] out_q;
  logic [1:0] hp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q <= '0;
      hp_q  <= '0;
    end else begin
      for (int i = 0; i < 4; i++) begin
        if (uf[i] && (ctrl[i][7] || poly5))
          out_q[i] <= ctrl[i][5] ? ~out_q[i] : (ctrl[i][6] ? poly4 : poly_long);
      end
      if (uf[2]) hp_q[0] <= out_q[0];
      if (uf[3]) hp_q[1] <= out_q[1];
    end
  end

  logic [3:0] eff, on;
  assign eff[0] = out_q[0] ^ (gctl[2] & hp_q[0]);
  assign eff[1] = out_q[1] ^ (gctl[1] & hp_q[1]);
  assign eff[2] = out_q[2];
  assign eff[3] = out_q[3];

  assign on[0] = ctrl[0][4] | (eff[0] & ~pair[0]);
  assign on[1] = ctrl[1][4] | eff[1];
  assign on[2] = ctrl[2][4] | (eff[2] & ~pair[1]);
  assign on[3] = ctrl[3][4] | eff[3];

  logic [5:0] level;
  always_comb begin
    level = '0;
    for (int i = 0; i < 4; i++)
      if (on[i]) level = level + {2'b00, ctrl[i][3:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mix_out <= '0;
    else        mix_out <= level;
  end
endmodule

// File: rtl/poly_tone_gen_chk.sv
module poly_tone_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] rnd_data,
  input logic [5:0] mix_out,
  input logic       long_sel,
  input logic       pair0,
  input logic [3:0] uf,
  input logic [3:0] out_q
);
  assert_reset_rnd_R1: assert property (@(posedge clk) $rose(rst_n) |-> rnd_data == 8'hFF);

  assert_mix_range_R2: assert property (@(posedge clk) disable iff (!rst_n) mix_out <= 6'd60);

  assert_toggle_on_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q[0] != $past(out_q[0])) |-> $past(uf[0]));

  assert_pair_low_still_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pair0 && $past(pair0)) |-> $stable(out_q[0]));

  assert_rnd_shift_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (long_sel == $past(long_sel)) |-> rnd_data[7:1] == $past(rnd_data[6:0]));

  assert_hp_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q[2] != $past(out_q[2])) |-> $past(uf[2]));
endmodule

bind poly_tone_gen poly_tone_gen_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rnd_data (rnd_data),
  .mix_out  (mix_out),
  .long_sel (gctl[7]),
  .pair0    (gctl[4]),
  .uf       (uf),
  .out_q    (out_q)
);

// File: tb/poly_tone_gen_tb.sv
module poly_tone_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rnd_data;
  logic [5:0] mix_out;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  poly_tone_gen u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rnd_data(rnd_data), .mix_out(mix_out)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic edge_stamp(output int st);
    logic [5:0] prev;
    int guard;
    prev = mix_out;
    guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (mix_out == prev && guard < 5000);
    st = cyc;
  endtask

  task automatic interval(output int d);
    int a, b;
    edge_stamp(a);
    edge_stamp(b);
    d = b - a;
  endtask

  task automatic t_reset();
    int bad;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(mix_out == 6'd0, "R1 mix in reset", mix_out, 0);
    chk(rnd_data == 8'hFF, "R1 rnd in reset", rnd_data, 255);
    rst_n = 1'b1;
    bad = 0;
    repeat (50) begin
      @(negedge clk);
      if (mix_out != 0) bad++;
    end
    chk(bad == 0, "R1 silent after reset", bad, 0);
  endtask

  task automatic t_volume();
    do_reset();
    wr(4'd1, 8'h19);
    repeat (2) @(negedge clk);
    chk(mix_out == 6'd9, "R2 single forced voice", mix_out, 9);
    wr(4'd3, 8'h1F); wr(4'd5, 8'h1F); wr(4'd7, 8'h1F); wr(4'd1, 8'h1F);
    repeat (2) @(negedge clk);
    chk(mix_out == 6'd60, "R2 four forced voices", mix_out, 60);
  endtask

  task automatic t_tone_fast();
    int d, s;
    do_reset();
    wr(4'd1, 8'hA5); wr(4'd0, 8'd4); wr(4'd8, 8'h40);
    edge_stamp(s);
    interval(d);
    chk(d == 5, "R3 fast tone half period", d, 5);
    chk(mix_out == 0 || mix_out == 5, "R3 tone level", mix_out, 5);
    interval(d);
    chk(d == 5, "R3 fast tone second half period", d, 5);
  endtask

  task automatic t_base_clock();
    int d, s;
    do_reset();
    wr(4'd1, 8'hA5);
    edge_stamp(s);
    interval(d);
    chk(d == 28, "R4 base tick divider 0", d, 28);
    wr(4'd0, 8'd1);
    edge_stamp(s); edge_stamp(s);
    interval(d);
    chk(d == 56, "R4 base tick divider 1", d, 56);
  endtask

  task automatic t_slow_clock();
    int d, s;
    do_reset();
    wr(4'd1, 8'hA5); wr(4'd8, 8'h01);
    edge_stamp(s); edge_stamp(s);
    interval(d);
    chk(d == 114, "R4 slow base tick", d, 114);
  endtask

  task automatic t_pair();
    int d, s;
    do_reset();
    wr(4'd0, 8'h02); wr(4'd2, 8'h01); wr(4'd3, 8'hA7); wr(4'd8, 8'h50);
    edge_stamp(s); edge_stamp(s);
    interval(d);
    chk(d == 259, "R5 chained voices 0/1 period", d, 259);
    chk(mix_out == 0 || mix_out == 7, "R5 low voice silent", mix_out, 7);
    do_reset();
    wr(4'd4, 8'h00); wr(4'd6, 8'h01); wr(4'd7, 8'hA3); wr(4'd8, 8'h28);
    edge_stamp(s); edge_stamp(s);
    interval(d);
    chk(d == 257, "R5 chained voices 2/3 period", d, 257);
  endtask

  task automatic t_no_restart();
    int a, b, c;
    do_reset();
    wr(4'd1, 8'hA5); wr(4'd0, 8'd9); wr(4'd8, 8'h40);
    edge_stamp(a);
    edge_stamp(a);
    wr(4'd0, 8'd2);
    edge_stamp(b);
    chk(b - a == 10, "R6 running count kept", b - a, 10);
    edge_stamp(c);
    chk(c - b == 3, "R6 new value after reload", c - b, 3);
  endtask

  task automatic t_hp_fast();
    int hi, other;
    do_reset();
    wr(4'd1, 8'hA6); wr(4'd0, 8'd4); wr(4'd4, 8'd0); wr(4'd5, 8'h00); wr(4'd8, 8'h64);
    repeat (10) @(negedge clk);
    hi = 0; other = 0;
    repeat (40) begin
      @(negedge clk);
      if (mix_out == 6) hi++;
      else if (mix_out != 0) other++;
    end
    chk(hi == 8, "R8 voice 0 high-pass pulses", hi, 8);
    chk(other == 0, "R8 voice 0 high-pass levels", other, 0);
  endtask

  task automatic t_hp_base();
    int bad;
    do_reset();
    wr(4'd3, 8'hA9); wr(4'd8, 8'h02);
    repeat (60) @(negedge clk);
    bad = 0;
    repeat (200) begin
      @(negedge clk);
      if (mix_out != 9) bad++;
    end
    chk(bad == 0, "R8 voice 1 gated by equal voice 3", bad, 0);
  endtask

  task automatic t_noise4();
    logic [5:0] s [45];
    int mism, ones;
    do_reset();
    wr(4'd1, 8'hC5); wr(4'd8, 8'h40);
    repeat (10) @(negedge clk);
    for (int i = 0; i < 45; i++) begin
      @(negedge clk);
      s[i] = mix_out;
    end
    mism = 0; ones = 0;
    for (int i = 0; i < 30; i++) if (s[i] != s[i+15]) mism++;
    for (int i = 0; i < 15; i++) if (s[i] == 5) ones++;
    chk(mism == 0, "R7 4-bit noise period 15", mism, 0);
    chk(ones == 8, "R7 4-bit noise ones", ones, 8);
  endtask

  task automatic t_gate5();
    logic [5:0] s [70];
    int mism, chg;
    do_reset();
    wr(4'd1, 8'h25); wr(4'd8, 8'h40);
    repeat (10) @(negedge clk);
    for (int i = 0; i < 70; i++) begin
      @(negedge clk);
      s[i] = mix_out;
    end
    mism = 0; chg = 0;
    for (int i = 0; i < 39; i++) if (s[i] != s[i+31]) mism++;
    for (int i = 0; i < 31; i++) if (s[i] != s[i+1]) chg++;
    chk(mism == 0, "R7 5-bit gated tone period 31", mism, 0);
    chk(chg == 16, "R7 5-bit gated toggles", chg, 16);
  endtask

  task automatic t_noise9();
    logic [5:0] s [530];
    int mism, ones;
    do_reset();
    wr(4'd1, 8'h85); wr(4'd8, 8'hC0);
    repeat (10) @(negedge clk);
    for (int i = 0; i < 530; i++) begin
      @(negedge clk);
      s[i] = mix_out;
    end
    mism = 0; ones = 0;
    for (int i = 0; i < 19; i++) if (s[i] != s[i+511]) mism++;
    for (int i = 0; i < 511; i++) if (s[i] == 5) ones++;
    chk(mism == 0, "R7 9-bit noise period 511", mism, 0);
    chk(ones == 256, "R7 9-bit noise ones", ones, 256);
  endtask

  task automatic t_rnd9();
    logic [7:0] r [520];
    int mism, chg;
    do_reset();
    wr(4'd8, 8'h80);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 520; i++) begin
      @(negedge clk);
      r[i] = rnd_data;
    end
    mism = 0; chg = 0;
    for (int i = 0; i < 9; i++) if (r[i] != r[i+511]) mism++;
    for (int i = 0; i < 20; i++) if (r[i] != r[i+1]) chg++;
    chk(mism == 0, "R9 short random period 511", mism, 0);
    chk(chg > 0, "R9 short random moves", chg, 1);
    chk(r[1][7:1] == r[0][6:0], "R9 random shifts one bit", r[1], {1'b0, r[0][6:0]});
  endtask

  task automatic t_rnd17();
    logic [7:0] a [8];
    logic [7:0] b [8];
    logic [7:0] c [8];
    int mab, mac;
    do_reset();
    for (int i = 0; i < 8; i++) begin @(negedge clk); a[i] = rnd_data; end
    repeat (503) @(negedge clk);
    for (int i = 0; i < 8; i++) begin @(negedge clk); b[i] = rnd_data; end
    repeat (130552) @(negedge clk);
    for (int i = 0; i < 8; i++) begin @(negedge clk); c[i] = rnd_data; end
    mab = 0; mac = 0;
    for (int i = 0; i < 8; i++) begin
      if (a[i] != b[i]) mab++;
      if (a[i] != c[i]) mac++;
    end
    chk(mab > 0, "R9 long random not period 511", mab, 1);
    chk(mac == 0, "R9 long random period 131071", mac, 0);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_volume();
    t_tone_fast();
    t_base_clock();
    t_slow_clock();
    t_pair();
    t_no_restart();
    t_hp_fast();
    t_hp_base();
    t_noise4();
    t_gate5();
    t_noise9();
    t_rnd9();
    t_rnd17();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule